// File: doc/BRIEF.md
# Biphase-Mark Clock and Command Recovery

This block takes one serial line carrying biphase-mark coded data and recovers two things from it: a bit-rate clock and the stream of command bits. In biphase-mark coding the line always changes level at the start of every bit cell. A one adds a second change halfway through the cell. The line is sampled by a local clock that runs OVS times faster than the bit rate. A phase counter locks onto the cell-start transitions and produces a recovered clock that is high for the first half of each cell and low for the second half. A command bit is taken as one only when a transition lands in the window around the middle of the cell.

Once lock is acquired, a settling interval of SETTLE_CELLS cells follows, and the command output stays at zero for its duration. If the cell-start transitions stop for LOS_CELLS cells in a row, the block reports loss of signal, stops the recovered clock and starts the settling interval again. The recovered clock and the command bit go out on two sets of ports, a main set and a spare set. Each set has its own gate input. With both gate inputs low, the main set is live and the spare set idles low.

Top module: `bmc_clk_cmd_decoder`

## Requirements
- R1: `line_in` is sampled on every `clk` edge and passes two synchroniser stages. A level change is therefore acted on by the phase logic on the third rising edge after it is first sampled.
- R2: After reset, and whenever lock is lost, `sig_lost` is 1 and all four clock and command outputs are 0. The first observed transition sets lock, and that transition's sample becomes phase 0 of a cell.
- R3: Phase counts 0 to OVS-1 and then wraps. A transition observed at a phase above 3*OVS/4 or below OVS/4 is a cell start: the next sample becomes phase 1.
- R4: The recovered clock is high at phases 0 to OVS/2-1 and low otherwise. On a jitter-free stream every high pulse therefore lasts OVS/2 clocks, whatever the data.
- R5: A transition observed at a phase from OVS/4 to 3*OVS/4 inclusive marks the current cell as a one. A cell with no such transition is a zero.
- R6: The command output is loaded at the last phase (OVS-1) of each cell. It holds that cell's value for the whole of the following cell, which is a delay of one cell.
- R7: The command output is 0 until SETTLE_CELLS complete cells have passed since lock was acquired.
- R8: The cell-start check is made once per cell, at phase OVS/2. If LOS_CELLS checks in a row find no cell-start transition since the previous check, lock is dropped: `sig_lost` rises, the clocks stop, the command output clears and settling restarts.
- R9: `main_mute`=1 holds `clk_main` and `cmd_main` at 0. `main_mute`=0 passes the recovered clock and the command bit through.
- R10: `spare_enable`=0 holds `clk_spare` and `cmd_spare` at 0. `spare_enable`=1 passes them through. With both gate inputs at 0, only the main set is live.
- R11: Transitions delayed by up to OVS/8 samples from their nominal place decode to the same bits as the jitter-free stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sliced biphase-mark serial line |
| main_mute | input | 1 | 1 forces the main outputs low |
| spare_enable | input | 1 | 1 enables the spare outputs |
| clk_main | output | 1 | Recovered clock, main copy |
| cmd_main | output | 1 | Decoded command bit, main copy |
| clk_spare | output | 1 | Recovered clock, spare copy |
| cmd_spare | output | 1 | Decoded command bit, spare copy |
| sig_lost | output | 1 | 1 while the block is not locked |

## Verification
The stimulus has five parts:

- A long all-zero preamble. It acquires lock and runs out the settling interval with only cell-start transitions present.
- Frames of 128 cells, each holding one burst of seven ones, sent with one-sample delay jitter. These show whether the mid-cell window and the re-alignment tell jittered ones apart from cell starts.
- A random jitter-free section. It separates a recovered-clock duty error from data-dependent phase drift.
- A silent gap, which exercises loss of signal.
- Random data straight after relock. This shows whether settling suppression is restarted.

Both gates are toggled during the frames, so the burst count seen on each output set also tells whether the gates work.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   typedef enum logic {
      ZONE_EDGE = 1'b0,
      ZONE_MID  = 1'b1
   } zone_e;

   // Cell-start zone lies outside the central half of the cell
   function automatic zone_e zone_of(input int unsigned phase, input int unsigned ovs);
      return (phase > (3 * ovs) / 4 || phase < ovs / 4) ? ZONE_EDGE : ZONE_MID;
   endfunction

endpackage

// File: rtl/bmc_line_sync.sv
module bmc_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic toggled
);

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];

   assign level   = chain[STAGES-1];
   assign toggled = level ^ prev;

endmodule

// File: rtl/bmc_phase_track.sv
module bmc_phase_track
   import bmc_pkg::*;
#(
   parameter  int OVS       = 8,
   parameter  int LOS_CELLS = 3,
   localparam int PW        = $clog2(OVS),
   localparam int MW        = $clog2(LOS_CELLS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_seen,
   output logic [PW-1:0] ph,
   output logic          locked,
   output logic          cell_end,
   output logic          cell_bit,
   output logic          rclk
);

   logic [PW-1:0] ph_next;
   logic [MW-1:0] miss;
   logic          bnd_seen, mid_seen;
   logic          in_edge_zone, bnd_hit, mid_hit;

   always_comb begin
      in_edge_zone = (zone_of(32'(ph), OVS) == ZONE_EDGE);
      bnd_hit      = edge_seen && in_edge_zone;
      mid_hit      = edge_seen && !in_edge_zone;
      cell_end     = locked && (ph == PW'(OVS - 1));
      rclk         = locked && (ph < PW'(OVS / 2));
      if (bnd_hit)                 ph_next = PW'(1);
      else if (ph == PW'(OVS - 1)) ph_next = '0;
      else                         ph_next = ph + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= '0;
         locked   <= 1'b0;
         bnd_seen <= 1'b0;
         mid_seen <= 1'b0;
         miss     <= '0;
      end else if (!locked) begin
         mid_seen <= 1'b0;
         miss     <= '0;
         if (edge_seen) begin
            locked   <= 1'b1;
            ph       <= PW'(1);
            bnd_seen <= 1'b1;
         end
      end else begin
         ph <= ph_next;
         if (ph == PW'(OVS / 2)) begin
            bnd_seen <= 1'b0;
            if (bnd_seen)                        miss   <= '0;
            else if (miss == MW'(LOS_CELLS - 1)) locked <= 1'b0;
            else                                 miss   <= miss + 1'b1;
         end else if (bnd_hit) begin
            bnd_seen <= 1'b1;
         end
         if (ph == PW'(OVS - 1)) mid_seen <= 1'b0;
         else if (mid_hit)       mid_seen <= 1'b1;
      end
   end

   assign cell_bit = mid_seen;

endmodule

// File: rtl/bmc_settle.sv
module bmc_settle #(
   parameter  int SETTLE_CELLS = 40,
   localparam int CW           = $clog2(SETTLE_CELLS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic locked,
   input  logic cell_end,
   output logic settled
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                     cnt <= '0;
      else if (!locked)                               cnt <= '0;
      else if (cell_end && cnt != CW'(SETTLE_CELLS))  cnt <= cnt + 1'b1;

   assign settled = (cnt == CW'(SETTLE_CELLS));

endmodule

// File: rtl/bmc_clk_cmd_decoder.sv
module bmc_clk_cmd_decoder #(
   parameter  int OVS          = 8,
   parameter  int SETTLE_CELLS = 40,
   parameter  int LOS_CELLS    = 3,
   parameter  int SYNC_STAGES  = 2,
   localparam int PW           = $clog2(OVS),
   localparam int NSETS        = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic main_mute,
   input  logic spare_enable,
   output logic clk_main,
   output logic cmd_main,
   output logic clk_spare,
   output logic cmd_spare,
   output logic sig_lost
);

   if (OVS < 8 || (OVS % 4) != 0) begin : g_bad_ovs
      $error("OVS must be a multiple of 4 and at least 8");
   end
   if (SETTLE_CELLS < 1 || LOS_CELLS < 1) begin : g_bad_cnt
      $error("SETTLE_CELLS and LOS_CELLS must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic          line_lvl, edge_seen;
   logic [PW-1:0] ph;
   logic          locked, cell_end, cell_bit, rclk, settled, cmd_q;

   bmc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (line_in),
      .level   (line_lvl),
      .toggled (edge_seen)
   );

   bmc_phase_track #(.OVS(OVS), .LOS_CELLS(LOS_CELLS)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_seen (edge_seen),
      .ph        (ph),
      .locked    (locked),
      .cell_end  (cell_end),
      .cell_bit  (cell_bit),
      .rclk      (rclk)
   );

   bmc_settle #(.SETTLE_CELLS(SETTLE_CELLS)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked),
      .cell_end (cell_end),
      .settled  (settled)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cmd_q <= 1'b0;
      else if (!locked)  cmd_q <= 1'b0;
      else if (cell_end) cmd_q <= settled && cell_bit;

   logic [NSETS-1:0] set_en, clk_set, cmd_set;
   assign set_en = {spare_enable, ~main_mute};

   for (genvar g = 0; g < NSETS; g++) begin : g_out
      assign clk_set[g] = rclk  & set_en[g];
      assign cmd_set[g] = cmd_q & set_en[g];
   end

   assign clk_main  = clk_set[0];
   assign cmd_main  = cmd_set[0];
   assign clk_spare = clk_set[1];
   assign cmd_spare = cmd_set[1];
   assign sig_lost  = ~locked;

   // line_lvl is kept for observability of the synchronised line
   logic unused_lvl;
   assign unused_lvl = line_lvl;

endmodule

// File: rtl/bmc_clk_cmd_decoder_chk.sv
module bmc_clk_cmd_decoder_chk #(
   parameter  int OVS          = 8,
   parameter  int SETTLE_CELLS = 40,
   localparam int PW           = $clog2(OVS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [PW-1:0] ph,
   input logic          locked,
   input logic          cell_end,
   input logic          settled,
   input logic          cmd_q,
   input logic          clk_main,
   input logic          clk_spare,
   input logic          cmd_main,
   input logic          sig_lost
);

   localparam int MIN_SETTLE = SETTLE_CELLS * (OVS / 2);

   int since_lock;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      since_lock <= 0;
      else if (!locked)                since_lock <= 0;
      else if (since_lock < MIN_SETTLE) since_lock <= since_lock + 1;

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ph) < OVS);                                                    // R3

   AST_CLOCK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      sig_lost |-> (!clk_main && !clk_spare));                           // R2

   AST_CMD_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      sig_lost |=> !cmd_main);                                           // R8

   AST_CMD_AT_CELL_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_q) |-> ($past(cell_end) || $past(!locked)));          // R6

   AST_SETTLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> since_lock >= MIN_SETTLE);                             // R7

endmodule

bind bmc_clk_cmd_decoder bmc_clk_cmd_decoder_chk #(
   .OVS          (OVS),
   .SETTLE_CELLS (SETTLE_CELLS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ph        (ph),
   .locked    (locked),
   .cell_end  (cell_end),
   .settled   (settled),
   .cmd_q     (cmd_q),
   .clk_main  (clk_main),
   .clk_spare (clk_spare),
   .cmd_main  (cmd_main),
   .sig_lost  (sig_lost)
);

// File: tb/bmc_clk_cmd_decoder_test.sv
module bmc_clk_cmd_decoder_test;

   localparam int OVS    = 8;
   localparam int SETTLE = 40;
   localparam int LOS    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0, line_in = 1'b0, main_mute = 1'b0, spare_enable = 1'b0;
   logic clk_main, cmd_main, clk_spare, cmd_spare, sig_lost;

   always #5 clk = ~clk;

   bmc_clk_cmd_decoder #(.OVS(OVS), .SETTLE_CELLS(SETTLE), .LOS_CELLS(LOS)) uut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .main_mute(main_mute),
      .spare_enable(spare_enable), .clk_main(clk_main), .cmd_main(cmd_main),
      .clk_spare(clk_spare), .cmd_spare(cmd_spare), .sig_lost(sig_lost));

   int vectors = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
      end
   endtask

   // stimulus: list of transition sample indices
   int edges[$];
   int t = 16;
   int k_seg2, k_sp0, k_sp1, k_mu0, k_mu1, k_seg3, k_seg3e, k_seg4, k_end;

   task automatic add_cells(input int n, input int kind, input bit jit);
      for (int c = 0; c < n; c++) begin
         bit one;
         int jb, jm;
         case (kind)
            0:       one = 1'b0;
            1:       one = (c % 128) >= 20 && (c % 128) <= 26;
            default: one = 1'($urandom_range(0, 1));
         endcase
         jb = jit ? int'($urandom_range(0, OVS / 8)) : 0;
         jm = jit ? int'($urandom_range(0, OVS / 8)) : 0;
         edges.push_back(t + jb);
         if (one) edges.push_back(t + OVS / 2 + jm);
         t += OVS;
      end
   endtask

   // behavioural reference state
   int m_s1, m_s2, m_s3, m_ph, m_lock, m_bseen, m_miss, m_one, m_cnt, m_cmd;

   task automatic model_step(input bit rst_active, input int x);
      bit e, bnd, cend;
      int n_ph, n_lock, n_bseen, n_miss, n_one, n_cnt, n_cmd;
      if (rst_active) begin
         {m_s1, m_s2, m_s3, m_ph, m_lock, m_bseen, m_miss, m_one, m_cnt, m_cmd} = '0;
         return;
      end
      e = (m_s2 != m_s3);
      n_ph = m_ph; n_lock = m_lock; n_bseen = m_bseen; n_miss = m_miss;
      n_one = m_one; n_cnt = m_cnt; n_cmd = m_cmd;
      if (m_lock == 0) begin
         n_one = 0; n_miss = 0; n_cnt = 0; n_cmd = 0;
         if (e) begin n_lock = 1; n_ph = 1; n_bseen = 1; end
      end else begin
         bnd  = (m_ph > 3 * OVS / 4) || (m_ph < OVS / 4);
         cend = (m_ph == OVS - 1);
         if (cend) n_cmd = (m_cnt == SETTLE && m_one != 0) ? 1 : 0;
         if (cend && m_cnt != SETTLE) n_cnt = m_cnt + 1;
         n_ph = (e && bnd) ? 1 : (m_ph + 1) % OVS;
         if (m_ph == OVS / 2) begin
            n_bseen = 0;
            if (m_bseen != 0)       n_miss = 0;
            else if (m_miss == LOS - 1) n_lock = 0;
            else                    n_miss = m_miss + 1;
         end else if (e && bnd) n_bseen = 1;
         if (cend) n_one = 0;
         else if (e && !bnd) n_one = 1;
      end
      m_ph = n_ph; m_lock = n_lock; m_bseen = n_bseen; m_miss = n_miss;
      m_one = n_one; m_cnt = n_cnt; m_cmd = n_cmd;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = x;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      int ei = 0, lvl = 0, k;
      int run = 0, run_k0 = 0, prev_clk = 0;
      int main_rises = 0, spare_rises = 0, prev_cm = 0, prev_cs = 0;
      int lock_fall_k = -1, prev_lost = 1, early_ones = 0, saw_los = 0;
      bit rclk_m;

      add_cells(60, 0, 1'b0);                 // preamble, lock and settle
      k_seg2 = t;
      add_cells(3 * 128, 1, 1'b1);            // bursts with jitter (R11)
      k_sp0 = k_seg2 + 128 * OVS; k_sp1 = k_seg2 + 256 * OVS;
      k_mu0 = k_sp1;              k_mu1 = k_seg2 + 384 * OVS;
      k_seg3 = t;
      add_cells(100, 2, 1'b0);                // random, jitter-free (R4)
      k_seg3e = t;
      t += 6 * OVS;                           // silence (R8)
      k_seg4 = t;
      add_cells(110, 2, 1'b1);                // random right after relock (R7)
      k_end = t + 4 * OVS;

      for (int n = 0; n < k_end + 10; n++) begin
         @(negedge clk);
         k = n - 10;
         model_step(!rst_n, int'(line_in));
         rclk_m = (m_lock != 0) && (m_ph < OVS / 2);

         if (n == 3) begin                    // reset state (R2)
            chk("R2", "sig_lost in reset", int'(sig_lost), 1);
            chk("R2", "clk_main in reset", int'(clk_main), 0);
            chk("R2", "cmd_main in reset", int'(cmd_main), 0);
         end

         chk("R3 R4 R9",  "clk_main",  int'(clk_main),  int'(rclk_m && !main_mute));
         chk("R5 R6 R7",  "cmd_main",  int'(cmd_main),  int'(m_cmd != 0 && !main_mute));
         chk("R10",       "clk_spare", int'(clk_spare), int'(rclk_m && spare_enable));
         chk("R10",       "cmd_spare", int'(cmd_spare), int'(m_cmd != 0 && spare_enable));
         chk("R1 R2 R8",  "sig_lost",  int'(sig_lost),  int'(m_lock == 0));

         // jitter-free duty (R4): every high pulse is OVS/2 long
         if (clk_main) begin
            if (!prev_clk) begin run = 0; run_k0 = k; end
            run++;
         end else if (prev_clk && run_k0 >= k_seg3 + 5 * OVS && k <= k_seg3e) begin
            chk("R4", "high pulse length", run, OVS / 2);
         end
         prev_clk = int'(clk_main);

         // burst counts per output set (R5 R11 R9 R10)
         if (cmd_main && !prev_cm && k >= k_seg2 && k < k_sp1 + 2 * OVS) main_rises++;
         if (cmd_spare && !prev_cs) spare_rises++;
         prev_cm = int'(cmd_main); prev_cs = int'(cmd_spare);

         // relock behaviour (R8 R7)
         if (k >= k_seg3e && sig_lost) saw_los = 1;
         if (k >= k_seg3e && prev_lost && !sig_lost) lock_fall_k = k;
         if (lock_fall_k >= 0 && cmd_main && (k - lock_fall_k) < SETTLE * (OVS - 1)) early_ones++;
         prev_lost = int'(sig_lost);

         // drive next inputs
         if (n == 4) rst_n = 1'b1;
         if (k >= 0) begin
            if (ei < edges.size() && edges[ei] == k) begin lvl = 1 - lvl; ei++; end
            line_in      = 1'(lvl);
            spare_enable = (k >= k_sp0 && k < k_sp1);
            main_mute    = (k >= k_mu0 && k < k_mu1);
         end
      end

      chk("R5 R11", "bursts seen on main in frames 1-2", main_rises, 2);
      chk("R10",    "bursts seen on spare",              spare_rises, 1);
      chk("R8",     "loss of signal during silence",     saw_los, 1);
      chk("R7",     "ones during settling after relock", early_ones, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule